// File: doc/BRIEF.md
# Half-duplex parallel bus peripheral

This block is the peripheral end of an 8-bit parallel link to a host controller. The data bus is shared and changes direction under host control. A bus clock from the host sets the pace. Two host-driven lines, a direction line and a request line, frame the command phase. While both lines are high, the host puts one command byte on the bus after each falling bus-clock edge. The block captures each byte on the next rising edge and hands it to a local consumer over a valid/ready stream.

When the host lowers the direction and request lines it releases the bus. The block then waits for a turnaround of one full bus-clock period with its pads off. After that it takes the bus and raises its own request line. It then returns one frame of `FRAME_W * FRAME_H * BYTES_PER_PIX` bytes from a local pixel stream. Each byte changes on a rising edge, so the host can sample it on the falling edge. The block raises a finish line together with the last byte and keeps it high until the host starts the next command phase.

All host-facing inputs are sampled in the system clock domain through a synchronizer. The bus pads sit outside the block, so the tristate bus appears as separate input, output and output-enable ports.

Top module: `pbus_periph`

## Requirements
- R1: After reset, `bus_oe`, `req_oe`, `req_o`, `fin_o`, `cmd_valid` and `pix_ready` are all 0.
- R2: A command byte is captured at each rising bus-clock edge that finds the direction and request lines both high, provided both were also high at the preceding falling edge. Captured bytes leave on the command stream in arrival order, exactly one per byte sent, and the bus value present before the first falling edge of the phase is never taken.
- R3: The block never drives the bus or the request line once the direction input has been high for more than `SYNC_STAGES` system clocks.
- R4: After the direction line goes low, the block turns on `bus_oe` and `req_oe` at the second rising bus-clock edge, and not before. At the falling edge between those two rising edges both enables are 0.
- R5: The return phase carries exactly `FRAME_W*FRAME_H*BYTES_PER_PIX` bytes (24 by default). The first byte appears with the request line, and each later byte appears on one later rising edge. Every byte is taken from the pixel stream with one `pix_ready` pulse, in stream order.
- R6: `fin_o` rises together with the last byte of the frame. It stays high through the idle time that follows and falls only when the direction and request lines are next both high.
- R7: Rising edges after the last byte leave the bus holding the last byte, with no further `pix_ready` pulse.
- R8: A byte loaded while `pix_valid` is 0 goes out as 0x00 and still counts toward the frame length.
- R9: During the whole return phase, `req_o` and `req_oe` are both 1.
- R10: `cmd_valid` stays high until `cmd_ready` is seen. A byte captured while an earlier one is still waiting replaces it, so the consumer sees the most recent byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bus clock from the host |
| dir_i | input | 1 | Host direction line |
| req_i | input | 1 | Host request line (command phase) |
| bus_i | input | DW | Data bus as seen at the pads |
| bus_o | output | DW | Data the block drives in the return phase |
| bus_oe | output | 1 | Pad output enable for the data bus |
| req_o | output | 1 | Request level driven in the return phase |
| req_oe | output | 1 | Pad output enable for the request line |
| fin_o | output | 1 | Frame complete |
| cmd_valid | output | 1 | Command byte available |
| cmd_data | output | DW | Command byte |
| cmd_ready | input | 1 | Consumer accepts the command byte |
| pix_valid | input | 1 | Pixel source has a byte |
| pix_data | input | DW | Pixel byte |
| pix_ready | output | 1 | Block takes the pixel byte this cycle |

## Verification
A wrong phase register or turnaround count shows up at the pads within one bus-clock period. Either the enables come up at the first rising edge after the direction drop, or they stay off at the second, and the host-side sample at the falling edge in between catches both cases. A byte counter that is off by one moves `fin_o` one byte early or late, and it changes the number of `pix_ready` pulses at the end of the frame. A stale capture-arming flag adds the idle bus value at the head of the command stream or drops the last command byte, and the byte count seen on the command stream exposes this as soon as the command phase ends.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Link phase as seen by the peripheral
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // waiting for host to open a command phase
    PH_CMD  = 2'd1,  // host drives the bus
    PH_TURN = 2'd2,  // bus released, counting turnaround edges
    PH_SEND = 2'd3   // peripheral drives the bus
  } pbus_phase_t;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          dir_i,
  input  logic          req_i,
  input  logic [DW-1:0] bus_i,
  output logic          dir_s,
  output logic          req_s,
  output logic [DW-1:0] bus_s,
  output logic          rise,
  output logic          fall
);

  localparam int W = DW + 3;

  logic [W-1:0] in_vec;
  logic [W-1:0] out_vec;
  logic         bclk_s;
  logic         bclk_prev;

  assign in_vec = {bclk_i, dir_i, req_i, bus_i};

  // All host lines travel through one chain so data stays aligned to the clock edge
  generate
    if (STAGES == 1) begin : g_one
      logic [W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= in_vec;
      end
      assign out_vec = sh_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], in_vec};
      end
      assign out_vec = sh_q[STAGES-1];
    end
  endgenerate

  assign bclk_s = out_vec[W-1];
  assign dir_s  = out_vec[W-2];
  assign req_s  = out_vec[W-3];
  assign bus_s  = out_vec[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= bclk_s;
  end

  assign rise = bclk_s & ~bclk_prev;
  assign fall = ~bclk_s & bclk_prev;

endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int FRAME_BYTES = 24,
  parameter int TURN_RISES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_s,
  input  logic req_s,
  input  logic rise,
  input  logic fall,
  output logic cap_en,
  output logic load_en,
  output logic drive_o,
  output logic fin_o
);

  localparam int CW = $clog2(FRAME_BYTES + 1);
  localparam int TW = (TURN_RISES > 1) ? $clog2(TURN_RISES) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_BYTES);
  localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_BYTES - 1);
  localparam logic [TW-1:0] TURN_END = TW'(TURN_RISES - 1);

  pbus_phase_t   ph_q, ph_n;
  logic          armed_q, armed_n;
  logic [TW-1:0] turn_q, turn_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          fin_q, fin_n;

  always_comb begin
    ph_n    = ph_q;
    armed_n = armed_q;
    turn_n  = turn_q;
    cnt_n   = cnt_q;
    fin_n   = fin_q;
    cap_en  = 1'b0;
    load_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (dir_s && req_s) begin
          ph_n    = PH_CMD;
          armed_n = 1'b0;
          fin_n   = 1'b0;
        end
      end
      PH_CMD: begin
        if (!dir_s) begin
          ph_n   = PH_TURN;
          turn_n = '0;
        end else begin
          if (fall) armed_n = req_s;
          if (rise && armed_q && req_s) cap_en = 1'b1;
        end
      end
      PH_TURN: begin
        if (dir_s) begin
          ph_n = PH_IDLE;
        end else if (rise) begin
          if (turn_q == TURN_END) begin
            ph_n    = PH_SEND;
            load_en = 1'b1;
            cnt_n   = CW'(1);
            fin_n   = (FRAME_BYTES == 1);
          end else begin
            turn_n = turn_q + 1'b1;
          end
        end
      end
      PH_SEND: begin
        if (dir_s) begin
          ph_n = PH_IDLE;
        end else if (rise && (cnt_q < FULL_CNT)) begin
          load_en = 1'b1;
          cnt_n   = cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) fin_n = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      armed_q <= 1'b0;
      turn_q  <= '0;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      armed_q <= armed_n;
      turn_q  <= turn_n;
      cnt_q   <= cnt_n;
      fin_q   <= fin_n;
    end
  end

  assign drive_o = (ph_q == PH_SEND);
  assign fin_o   = fin_q;

  // R3
  dir_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_s |=> !drive_o);

  // R6
  fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fin_q) |-> (ph_q == PH_CMD));

  // R5
  load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> drive_o);

  // R7
  send_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> (cnt_q != '0) && (cnt_q <= FULL_CNT));

endmodule

// File: rtl/pbus_cmd_rx.sv
module pbus_cmd_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] bus_s,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data
);

  logic          vld_q, vld_n;
  logic [DW-1:0] dat_q, dat_n;

  always_comb begin
    vld_n = vld_q;
    dat_n = dat_q;
    if (vld_q && cmd_ready) vld_n = 1'b0;
    if (cap_en) begin
      vld_n = 1'b1;
      dat_n = bus_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_n;
      dat_q <= dat_n;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_data  = dat_q;

  // R2
  cap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(cap_en));

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);

endmodule

// File: rtl/pbus_tx.sv
module pbus_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic [DW-1:0] bus_o
);

  logic [DW-1:0] out_q, out_n;

  always_comb begin
    out_n = out_q;
    if (load_en) out_n = pix_valid ? pix_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_n;
  end

  assign bus_o = out_q;

endmodule

// File: rtl/pbus_periph.sv
module pbus_periph #(
  parameter int DW            = 8,
  parameter int FRAME_W       = 4,
  parameter int FRAME_H       = 3,
  parameter int BYTES_PER_PIX = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int TURN_RISES    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          dir_i,
  input  logic          req_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe,
  output logic          req_o,
  output logic          req_oe,
  output logic          fin_o,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  input  logic          cmd_ready,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready
);

  localparam int FRAME_BYTES = FRAME_W * FRAME_H * BYTES_PER_PIX;

  logic [1:0]    rst_q;
  logic          rst_int_n;
  logic          dir_s, req_s, rise, fall;
  logic [DW-1:0] bus_s;
  logic          cap_en, load_en, drive;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  pbus_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bclk_i (bclk_i),
    .dir_i  (dir_i),
    .req_i  (req_i),
    .bus_i  (bus_i),
    .dir_s  (dir_s),
    .req_s  (req_s),
    .bus_s  (bus_s),
    .rise   (rise),
    .fall   (fall)
  );

  pbus_ctrl #(.FRAME_BYTES(FRAME_BYTES), .TURN_RISES(TURN_RISES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dir_s   (dir_s),
    .req_s   (req_s),
    .rise    (rise),
    .fall    (fall),
    .cap_en  (cap_en),
    .load_en (load_en),
    .drive_o (drive),
    .fin_o   (fin_o)
  );

  pbus_cmd_rx #(.DW(DW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cap_en    (cap_en),
    .bus_s     (bus_s),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data)
  );

  pbus_tx #(.DW(DW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .bus_o     (bus_o)
  );

  assign bus_oe    = drive;
  assign req_oe    = drive;
  assign req_o     = drive;
  assign pix_ready = load_en;

  // R4
  drive_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(bus_oe) |-> $past(rise));

  // R9
  req_with_bus_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_oe |-> (req_oe && req_o));

endmodule

// File: tb/tb_pbus_periph.sv
module tb_pbus_periph;

  localparam int DW   = 8;
  localparam int FW   = 4;
  localparam int FH   = 3;
  localparam int BPP  = 2;
  localparam int SYNC = 2;
  localparam int HALF = 8;
  localparam int NB   = FW * FH * BPP;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, bclk, dir, req, host_oe, cmd_ready, pix_valid;
  logic [DW-1:0] host_d, pix_base;
  int            pix_cnt = 0;
  int            pix_c0  = 0;
  logic [DW-1:0] bus_i, pix_data;
  logic [DW-1:0] bus_o, cmd_data;
  logic          bus_oe, req_o, req_oe, fin_o, cmd_valid, pix_ready;

  assign bus_i    = host_oe ? host_d : 8'h00;
  assign pix_data = pix_base + 8'(7 * (pix_cnt - pix_c0));

  pbus_periph #(.DW(DW), .FRAME_W(FW), .FRAME_H(FH), .BYTES_PER_PIX(BPP),
                .SYNC_STAGES(SYNC), .TURN_RISES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .dir_i(dir), .req_i(req),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .req_o(req_o),
    .req_oe(req_oe), .fin_o(fin_o), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready)
  );

  int tests = 0, fails = 0, mon_tests = 0, mon_fails = 0;

  // Edge-sampled reference state
  logic          hs = 1'b0;
  logic [DW-1:0] hsd = '0;
  int            dir_hi = 0;
  logic [DW-1:0] rx_q[$];

  always @(posedge clk) begin
    hs     <= cmd_valid && cmd_ready;
    hsd    <= cmd_data;
    dir_hi <= dir ? dir_hi + 1 : 0;
    if (pix_ready) pix_cnt <= pix_cnt + 1;
  end

  // Per-cycle monitor: command stream record and pad release (R3)
  always @(negedge clk) begin
    if (hs) rx_q.push_back(hsd);
    if (dir_hi > SYNC) begin
      mon_tests++;
      if (bus_oe || req_oe) begin
        mon_fails++;
        $display("FAIL R3 pads driven with dir high: actual oe=%0b/%0b expected 0/0",
                 bus_oe, req_oe);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic          s_oe, s_fin, s_req, s_reqoe;
  logic [DW-1:0] s_d;

  task automatic go_high();
    @(negedge clk); bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic fall_sample();
    @(negedge clk);
    s_oe = bus_oe; s_d = bus_o; s_fin = fin_o; s_req = req_o; s_reqoe = req_oe;
    bclk = 1'b0;
  endtask

  task automatic rest_low();
    repeat (HALF - 2) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] exp_byte(input logic [DW-1:0] seed, input bit pv, input int j);
    return pv ? seed + 8'(7 * j) : 8'h00;
  endfunction

  task automatic xfer(input int ncmd, input logic [DW-1:0] base, input logic [DW-1:0] seed,
                      input bit pv, input bit rdy, input int extra, input bit fin_before);
    logic [DW-1:0] exp_cmd[$];
    int  rx0, j;
    bit  done, first;
    rx0 = rx_q.size();
    pix_base = seed; pix_c0 = pix_cnt; pix_valid = pv; cmd_ready = rdy;
    // idle period, then open the command phase after a falling edge
    go_high(); fall_sample();
    chk(s_fin == fin_before, "R6 fin level in idle", s_fin, fin_before);
    @(negedge clk); dir = 1'b1; req = 1'b1;
    rest_low();
    first = 1'b1;
    for (int i = 0; i < ncmd; i++) begin
      go_high(); fall_sample();
      if (first) chk(!s_fin, "R6 fin cleared by new command phase", s_fin, 0);
      first = 1'b0;
      @(negedge clk); host_d = base + 8'(17 * i);
      if (rdy || i == ncmd - 1) exp_cmd.push_back(base + 8'(17 * i));
      rest_low();
    end
    go_high(); fall_sample();
    if (first) chk(!s_fin, "R6 fin cleared by new command phase", s_fin, 0);
    @(negedge clk); dir = 1'b0; req = 1'b0; host_oe = 1'b0;
    if (!rdy) begin
      chk(cmd_valid && cmd_data == exp_cmd[0], "R10 newest byte held", cmd_data, exp_cmd[0]);
      cmd_ready = 1'b1;
    end
    rest_low();
    // turnaround: pads stay off through the first falling edge
    go_high(); fall_sample();
    chk(!s_oe && !s_reqoe, "R4 pads off during turnaround", {s_oe, s_reqoe}, 0);
    @(negedge clk); rest_low();
    // return phase
    j = 0; done = 1'b0;
    while (!done && j < NB + 4) begin
      go_high(); fall_sample();
      if (j == 0) chk(s_oe && s_reqoe, "R4 pads on at second rise", {s_oe, s_reqoe}, 3);
      chk(s_req && s_reqoe, "R9 request held high", {s_req, s_reqoe}, 3);
      chk(s_d == exp_byte(seed, pv, j), pv ? "R5 frame byte" : "R8 zero byte",
          s_d, exp_byte(seed, pv, j));
      chk(s_fin == (j == NB - 1), "R6 fin with last byte", s_fin, (j == NB - 1));
      if (s_fin) done = 1'b1; else j++;
      @(negedge clk); rest_low();
    end
    chk(j == NB - 1, "R5 frame length", j + 1, NB);
    for (int e = 0; e < extra; e++) begin
      go_high(); fall_sample();
      chk(s_oe && s_fin && s_d == exp_byte(seed, pv, NB - 1), "R7 last byte held",
          s_d, exp_byte(seed, pv, NB - 1));
      @(negedge clk); rest_low();
    end
    chk(pix_cnt - pix_c0 == NB, "R5 R7 pixel handshakes", pix_cnt - pix_c0, NB);
    // host takes the bus back
    go_high(); fall_sample();
    @(negedge clk); dir = 1'b1; req = 1'b0; host_oe = 1'b1; host_d = 8'hFF;
    rest_low();
    chk(!bus_oe && !req_oe, "R3 pads released", {bus_oe, req_oe}, 0);
    chk(fin_o, "R6 fin held after release", fin_o, 1);
    chk(rx_q.size() - rx0 == exp_cmd.size(), "R2 command count", rx_q.size() - rx0, exp_cmd.size());
    for (int k = 0; k < exp_cmd.size() && rx0 + k < rx_q.size(); k++)
      chk(rx_q[rx0 + k] == exp_cmd[k], "R2 command byte", rx_q[rx0 + k], exp_cmd[k]);
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; dir = 1'b1; req = 1'b0; host_oe = 1'b1;
    host_d = 8'hFF; cmd_ready = 1'b1; pix_valid = 1'b1; pix_base = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!bus_oe && !req_oe && !req_o, "R1 pads off after reset", {bus_oe, req_oe, req_o}, 0);
    chk(!fin_o && !cmd_valid && !pix_ready, "R1 status low after reset",
        {fin_o, cmd_valid, pix_ready}, 0);
    xfer(5, 8'hA1, 8'h10, 1'b1, 1'b1, 2, 1'b0);
    xfer(1, 8'h33, 8'h80, 1'b1, 1'b1, 0, 1'b1);
    xfer(3, 8'h51, 8'h20, 1'b0, 1'b0, 1, 1'b1);
    xfer(0, 8'h00, 8'h44, 1'b1, 1'b1, 0, 1'b1);
    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end

endmodule